// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block lets software reach an external one-bit serial EEPROM through a memory port that it shares with one other requester. Software works through a single 8-bit control register. It sets a request bit and then polls a ready bit. Once the port is its own, it drives the EEPROM chip-select, clock and data-out pins directly and reads the data-in pin. Software carries out the EEPROM command protocol itself by toggling these bits. The block does not implement that protocol.

The ready bit has two uses. The first time it rises after a request, it only reports that the port has been granted, and no timing is implied. After that, every register write while the port is held clears ready. Ready then returns after a fixed settling delay of 800 ns, counted in system clocks and rounded up. Software uses this to pace each clock edge it drives onto the EEPROM. The other requester asserts a level request and holds the port until it drops that request. A transfer it already has in progress is never cut short.

Top module: `seeprom_port_arb`

## Requirements
- R1: During and after a synchronous active-high reset, reg_rdata bits 7..1 read 0, and other_gnt, eep_cs, eep_sk and eep_do are low.
- R2: Register bit 5 is the port request and reads back as written. A write setting it while the port is free grants the port on that clock edge, and ready (bit 4) reads 1 after the edge.
- R3: While the other requester holds the port, an EEPROM request waits. After other_req is seen low, the port becomes free on one edge and is granted on the following edge.
- R4: When the port is free and both requesters ask in the same cycle, the other requester wins and other_gnt goes high.
- R5: Any register write while the port is held and stays requested clears ready on that edge. Ready rises again exactly D = ceil(800 ns × clock frequency) clock edges later (D = 80 at 100 MHz).
- R6: A write made while the settling delay is running restarts the full D-cycle delay.
- R7: While the port is held, eep_cs, eep_sk and eep_do follow register bits 3, 2 and 1, changing on the edge that accepts the write.
- R8: While the port is not held by the EEPROM side, eep_cs, eep_sk and eep_do stay low, including after writes that set them.
- R9: A write clearing bit 5 releases the port on that edge: ready reads 0, and the three EEPROM pins go low.
- R10: Register bit 0 shows eep_di through a two-flop synchronizer and reflects a pin change after two clock edges.
- R11: Register bits 3..1 read back the last written control bits and read 0 after a release.
- R12: The other requester is not granted while the EEPROM side holds the port. It is granted on the edge after the release, and it keeps the port for as long as other_req stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data: bit 5 request, bit 3 select, bit 2 clock, bit 1 data-out |
| reg_rdata | output | 8 | Read data: bit 5 request, bit 4 ready, bits 3..1 control, bit 0 data-in |
| other_req | input | 1 | Level request from the competing memory-port user |
| other_gnt | output | 1 | Port granted to the competing user |
| eep_cs | output | 1 | EEPROM chip select |
| eep_sk | output | 1 | EEPROM serial clock |
| eep_do | output | 1 | Data toward the EEPROM |
| eep_di | input | 1 | Data from the EEPROM, asynchronous |

## Verification
The assertions assume that other_req is a level that stays high for the whole time the competing user holds the port, and that reg_wr is a single-cycle strobe that is never left high. They also assume that eep_di may change at any time relative to the clock. The stimulus drives every input on the falling edge, drops other_req only at the end of a competing transfer, and pulses each write for exactly one cycle. A behavioural reference model compares all outputs on every cycle, including the cycles when arbitration hands the port over and when the settling count runs out.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_OTHER = 2'd1,
    OWN_EEP   = 2'd2
  } owner_e;

  localparam int BIT_REQ = 5;
  localparam int BIT_RDY = 4;
  localparam int BIT_CS  = 3;
  localparam int BIT_SK  = 2;
  localparam int BIT_DO  = 1;
  localparam int BIT_DI  = 0;

  // clock cycles covering a delay in ns, rounded up; clock given in kHz
  function automatic int settle_cycles(input int delay_ns, input int clk_khz);
    return (delay_ns * clk_khz + 999_999) / 1_000_000;
  endfunction

endpackage

// File: rtl/seeprom_arb.sv
module seeprom_arb
  import seeprom_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   other_req,
  input  logic   eep_req,
  output owner_e owner_q,
  output owner_e owner_n,
  output logic   other_gnt
);

  always_comb begin
    owner_n = owner_q;
    case (owner_q)
      OWN_IDLE: begin
        if (other_req)    owner_n = OWN_OTHER;
        else if (eep_req) owner_n = OWN_EEP;
      end
      OWN_OTHER: if (!other_req) owner_n = OWN_IDLE;
      OWN_EEP:   if (!eep_req)   owner_n = OWN_IDLE;
      default:   owner_n = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_IDLE;
    else     owner_q <= owner_n;
  end

  assign other_gnt = (owner_q == OWN_OTHER);

  // R12: a running transfer of the other user is never cut short
  p_other_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_OTHER && other_req) |=> (owner_q == OWN_OTHER));

  // R12: the EEPROM side keeps the port while it still requests
  p_eep_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_EEP && eep_req) |=> (owner_q == OWN_EEP));

  // R3: hand-over always passes through the free state
  p_no_direct_r3: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_OTHER) |=> (owner_q != OWN_EEP));

endmodule

// File: rtl/seeprom_settle_timer.sv
module seeprom_settle_timer #(
  parameter int DELAY = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic grant_q,
  input  logic grant_n,
  input  logic wr,
  output logic ready
);

  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      cnt_q <= '0;
    end else if (!grant_n) begin
      ready <= 1'b0;
      cnt_q <= '0;
    end else if (!grant_q) begin
      ready <= 1'b1;          // grant indication, no timing implied
      cnt_q <= '0;
    end else if (wr) begin
      ready <= 1'b0;
      cnt_q <= CW'(DELAY);
    end else if (cnt_q == CW'(1)) begin
      ready <= 1'b1;
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R9: ready never shows without the port
  p_ready_needs_grant_r9: assert property (@(posedge clk) disable iff (rst)
    !grant_q |-> !ready);

  // R5: a write under grant always drops ready
  p_write_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (grant_q && grant_n && wr) |=> !ready);

  // R5: the countdown never exceeds its load value
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DELAY));

  // R6: ready is held low while a countdown is pending
  p_busy_low_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !ready);

endmodule

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/seeprom_port_arb.sv
module seeprom_port_arb
  import seeprom_pkg::*;
#(
  parameter int CLK_KHZ     = 100_000,
  parameter int SETTLE_NS   = 800,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       other_req,
  output logic       other_gnt,
  output logic       eep_cs,
  output logic       eep_sk,
  output logic       eep_do,
  input  logic       eep_di
);

  localparam int DELAY_RAW = settle_cycles(SETTLE_NS, CLK_KHZ);
  localparam int DELAY     = (DELAY_RAW < 1) ? 1 : DELAY_RAW;

  logic       req_q, req_n;
  logic [2:0] ctl_q, ctl_n;     // {select, clock, data-out}
  logic       ready;
  logic       di_s;
  owner_e     owner_q, owner_n;

  always_comb begin
    req_n = reg_wr ? reg_wdata[BIT_REQ] : req_q;
    ctl_n = reg_wr ? reg_wdata[BIT_CS:BIT_DO] : ctl_q;
    if (!req_n) ctl_n = 3'b000;
  end

  seeprom_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .other_req (other_req),
    .eep_req   (req_n),
    .owner_q   (owner_q),
    .owner_n   (owner_n),
    .other_gnt (other_gnt)
  );

  seeprom_settle_timer #(.DELAY(DELAY)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .grant_q (owner_q == OWN_EEP),
    .grant_n (owner_n == OWN_EEP),
    .wr      (reg_wr),
    .ready   (ready)
  );

  seeprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (eep_di),
    .q   (di_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      ctl_q  <= 3'b000;
      eep_cs <= 1'b0;
      eep_sk <= 1'b0;
      eep_do <= 1'b0;
    end else begin
      req_q <= req_n;
      ctl_q <= ctl_n;
      if (owner_n == OWN_EEP) begin
        eep_cs <= ctl_n[2];
        eep_sk <= ctl_n[1];
        eep_do <= ctl_n[0];
      end else begin
        eep_cs <= 1'b0;
        eep_sk <= 1'b0;
        eep_do <= 1'b0;
      end
    end
  end

  assign reg_rdata = {2'b00, req_q, ready, ctl_q, di_s};

  // R8: pins stay quiet whenever the EEPROM side lacks the port
  p_pins_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (owner_q != OWN_EEP) |-> !(eep_cs || eep_sk || eep_do));

  // R4: the other user's grant excludes any EEPROM activity
  p_mutex_r4: assert property (@(posedge clk) disable iff (rst)
    other_gnt |-> (!ready && !eep_cs && !eep_sk && !eep_do));

  // R9: a write clearing the request releases the port on that edge
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_wdata[BIT_REQ]) |=> (!ready && !eep_cs && !eep_sk && !eep_do));

endmodule

// File: tb/seeprom_port_arb_bench.sv
module seeprom_port_arb_bench;

  localparam int D = 80;   // 800 ns at 100 MHz

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       other_req = 1'b0;
  logic       other_gnt;
  logic       eep_cs, eep_sk, eep_do;
  logic       eep_di = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  seeprom_port_arb u_seeprom_port_arb (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .other_req(other_req), .other_gnt(other_gnt),
    .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_do(eep_do), .eep_di(eep_di)
  );

  // behavioural reference model: owner 0 free, 1 other, 2 eeprom
  int m_owner = 0;
  int m_req = 0, m_cs = 0, m_sk = 0, m_do = 0;
  int m_ready = 0, m_left = 0;
  int m_pin_cs = 0, m_pin_sk = 0, m_pin_do = 0;
  int m_di1 = 0, m_di2 = 0;

  always @(posedge clk) begin
    int req, cs, sk, dout, nxt;
    if (rst) begin
      m_owner = 0; m_req = 0; m_cs = 0; m_sk = 0; m_do = 0;
      m_ready = 0; m_left = 0; m_pin_cs = 0; m_pin_sk = 0; m_pin_do = 0;
      m_di1 = 0; m_di2 = 0;
    end else begin
      req = reg_wr ? int'(reg_wdata[5]) : m_req;
      cs = reg_wr ? int'(reg_wdata[3]) : m_cs;
      sk = reg_wr ? int'(reg_wdata[2]) : m_sk;
      dout = reg_wr ? int'(reg_wdata[1]) : m_do;
      if (req == 0) begin cs = 0; sk = 0; dout = 0; end
      nxt = m_owner;
      if (m_owner == 0) nxt = other_req ? 1 : (req != 0 ? 2 : 0);
      else if (m_owner == 1) nxt = other_req ? 1 : 0;
      else nxt = (req != 0) ? 2 : 0;
      if (nxt != 2) begin m_ready = 0; m_left = 0; end
      else if (m_owner != 2) begin m_ready = 1; m_left = 0; end
      else if (reg_wr) begin m_ready = 0; m_left = D; end
      else if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_ready = 1;
      end
      m_pin_cs = (nxt == 2) ? cs : 0;
      m_pin_sk = (nxt == 2) ? sk : 0;
      m_pin_do = (nxt == 2) ? dout : 0;
      m_di2 = m_di1; m_di1 = int'(eep_di);
      m_owner = nxt; m_req = req; m_cs = cs; m_sk = sk; m_do = dout;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 pins", {eep_cs, eep_sk, eep_do}, m_pin_cs * 4 + m_pin_sk * 2 + m_pin_do);
      chk("R5 ready", reg_rdata[4], m_ready);
      chk("R4 other_gnt", other_gnt, (m_owner == 1) ? 1 : 0);
      chk("R11 readback", reg_rdata,
          m_req * 32 + m_ready * 16 + m_cs * 8 + m_sk * 4 + m_do * 2 + m_di2);
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 pins", {eep_cs, eep_sk, eep_do}, 0);
    rst = 1'b0;
    idle(2);
    chk("R1 after reset", {reg_rdata[7:1], other_gnt, eep_cs, eep_sk, eep_do}, 0);

    wr(8'h28);                                   // request + select
    chk("R2 grant ready", reg_rdata[4], 1);
    chk("R2 request readback", reg_rdata[5], 1);
    chk("R7 select pin", eep_cs, 1);

    wr(8'h2C);                                   // raise clock
    chk("R5 ready dropped", reg_rdata[4], 0);
    chk("R7 clock pin", eep_sk, 1);
    idle(D - 1);
    chk("R5 ready still low", reg_rdata[4], 0);
    idle(1);
    chk("R5 ready back", reg_rdata[4], 1);

    wr(8'h2A);
    idle(40);
    wr(8'h2E);                                   // restart mid-delay
    chk("R11 control readback", reg_rdata[3:1], 3'b111);
    idle(D - 1);
    chk("R6 restarted delay low", reg_rdata[4], 0);
    idle(1);
    chk("R6 restarted delay done", reg_rdata[4], 1);

    eep_di = 1'b1;
    idle(1);
    chk("R10 one edge", reg_rdata[0], 0);
    idle(1);
    chk("R10 two edges", reg_rdata[0], 1);
    eep_di = 1'b0;

    other_req = 1'b1;
    idle(5);
    chk("R12 withheld", other_gnt, 0);
    wr(8'h00);                                   // release
    chk("R9 ready low", reg_rdata[4], 0);
    chk("R9 pins low", {eep_cs, eep_sk, eep_do}, 0);
    chk("R11 cleared", reg_rdata[3:1], 0);
    idle(1);
    chk("R12 granted after release", other_gnt, 1);

    wr(8'h2A);                                   // pending request
    chk("R8 data pin held low", eep_do, 0);
    chk("R3 waiting", reg_rdata[4], 0);
    idle(10);
    chk("R12 held while requested", other_gnt, 1);
    other_req = 1'b0;
    idle(1);
    chk("R3 free edge", reg_rdata[4], 0);
    idle(1);
    chk("R3 granted", reg_rdata[4], 1);
    chk("R7 data pin after grant", eep_do, 1);

    wr(8'h00);
    other_req = 1'b1;
    wr(8'h20);                                   // both ask while free
    chk("R4 other wins", other_gnt, 1);
    chk("R4 eeprom waits", reg_rdata[4], 0);
    idle(3);
    other_req = 1'b0;
    idle(2);
    chk("R3 second grant", reg_rdata[4], 1);
    wr(8'h00);
    idle(3);

    finish_run();
  end

endmodule